// File: doc/BRIEF.md
# Infrared 4PPM Transmit Framer

This block turns a stream of payload bytes into a serial chip stream for a fast-infrared link that uses four-position pulse modulation. Every symbol is four chips long and carries exactly one pulse, except inside the flags. The block moves one chip per chip-clock enable. Between frames it repeats an idle flag with no gaps. A start-of-frame strobe makes it finish the idle flag it is sending. It then sends a preamble train and a start flag. After that it takes bytes from an upstream buffer through a valid/ready handshake and sends each byte as four data symbols.

A frame ends in one of two ways. The first is a byte that carries the last tag: the block sends that byte and then a stop flag. The second is an upstream buffer that is empty at the moment a byte is needed: this is an underrun. The block then sends the stop flag at once, raises a one-cycle underrun pulse and sets a sticky status bit. That status bit drives the interrupt only while the interrupt enable is high. The preamble pattern and the three flags are constant parameters.

Top module: `irfr_tx_framer`

## Requirements
- R1: While `rst_ni` is low or `enable_i` is low, `chip_o`, `sym_start_o`, `tx_ready_o` and `urun_pulse_o` are 0 and the framer returns to idle. After `enable_i` rises, the first symbol sent is idle-flag symbol 0.
- R2: `chip_o` changes only on a clock edge where `chip_en_i` is high. `sym_start_o` is 1 exactly while `chip_o` holds chip 0 of a symbol. Chip k of a symbol is bit k of its 4-bit code, and chip 0 is sent first.
- R3: While idle, the block repeats the 8-symbol idle flag without pause. The default idle flag is 32'h06063030, and symbol j is bits [4j+3:4j].
- R4: A `sof_i` pulse taken while idle starts a frame once the current idle flag is complete. The frame opens with exactly 16 preamble units. Each unit is 4 symbols with codes 1, 2, 4, 8 (the default pattern is 16'h8421).
- R5: The 8-symbol start flag (default 32'h06063030) follows the preamble at once. Payload comes only after it.
- R6: Each payload byte becomes four symbols, starting with the most significant dibit. A dibit of value n becomes code 1<<n, so the pulse sits in chip n.
- R7: `tx_ready_o` is high only in the chip-enable cycle that loads the first symbol of a byte. One byte is taken per cycle in which `tx_valid_i` and `tx_ready_o` are both high.
- R8: After the four symbols of a byte taken with `tx_last_i` high, the 8-symbol stop flag (default 32'h60063030) is sent. Idle flags then resume from symbol 0, and no underrun is reported.
- R9: If `tx_valid_i` is low when a byte is due, the stop flag is sent at once with no data symbol. `urun_pulse_o` is high for the one cycle after that edge, and the sticky underrun status is set.
- R10: An empty buffer raises no underrun while the block is idle, sending the preamble or sending the start flag.
- R11: `irq_o` equals the sticky underrun status ANDed with `urun_ie_i`. A `urun_clr_i` pulse clears the status, and a new underrun wins over a clear in the same cycle.
- R12: A `sof_i` pulse that arrives while a frame is in progress is ignored, so no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Transmitter enable; when low, the framer is held in idle |
| chip_en_i | input | 1 | Chip-clock enable; one chip per pulse |
| sof_i | input | 1 | Start-of-frame strobe |
| tx_data_i | input | 8 | Payload byte |
| tx_last_i | input | 1 | Marks the final byte of a frame |
| tx_valid_i | input | 1 | Upstream buffer holds a byte |
| tx_ready_o | output | 1 | Byte accepted in this cycle when valid |
| chip_o | output | 1 | Serial chip output |
| sym_start_o | output | 1 | `chip_o` is chip 0 of a symbol |
| urun_ie_i | input | 1 | Underrun interrupt enable |
| urun_clr_i | input | 1 | Clears the sticky underrun status |
| urun_pulse_o | output | 1 | One-cycle underrun event |
| irq_o | output | 1 | Underrun interrupt request |

## Verification
Four payload byte sets are used:
- 0x1B and 0xE4 hold the dibits in ascending and in descending order. A swapped dibit order or a misplaced pulse position therefore shows up as a symbol mismatch.
- 0x00 and 0xFF put every pulse in one edge chip.
- A frame without a last tag shows a correct underrun ending next to the normal stop-flag ending.
- An empty frame shows the underrun exactly at the first byte fetch.

Chip-enable spacings of one, two and three clocks separate chip stepping from the plain clock. A start strobe in mid-frame and a disable in mid-frame test that the idle flag resumes at symbol 0.

// File: rtl/irfr_pkg.sv
package irfr_pkg;

  localparam int SYM_CHIPS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SOF,
    ST_DATA,
    ST_EOF
  } tx_state_e;

  function automatic logic [SYM_CHIPS-1:0] ppm_sym(input logic [1:0] dibit);
    return 4'b0001 << dibit;
  endfunction

  function automatic logic [1:0] pick_dibit(input logic [7:0] b, input logic [1:0] sel);
    logic [1:0] d;
    case (sel)
      2'd0:    d = b[7:6];
      2'd1:    d = b[5:4];
      2'd2:    d = b[3:2];
      default: d = b[1:0];
    endcase
    return d;
  endfunction

endpackage

// File: rtl/irfr_pattern_rom.sv
module irfr_pattern_rom #(
  parameter int PRE_SYMS  = 4,
  parameter int FLAG_SYMS = 8,
  parameter int IDX_W     = 6,
  parameter logic [4*PRE_SYMS-1:0]  PRE_PAT    = 16'h8421,
  parameter logic [4*FLAG_SYMS-1:0] START_FLAG = 32'h06063030,
  parameter logic [4*FLAG_SYMS-1:0] STOP_FLAG  = 32'h60063030,
  parameter logic [4*FLAG_SYMS-1:0] IDLE_FLAG  = 32'h06063030
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [3:0]       pre_sym_o,
  output logic [3:0]       start_sym_o,
  output logic [3:0]       stop_sym_o,
  output logic [3:0]       idle_sym_o
);

  localparam int PSEL_W = (PRE_SYMS > 1) ? $clog2(PRE_SYMS) : 1;
  localparam int FSEL_W = (FLAG_SYMS > 1) ? $clog2(FLAG_SYMS) : 1;

  logic [3:0] pre_tab   [PRE_SYMS];
  logic [3:0] start_tab [FLAG_SYMS];
  logic [3:0] stop_tab  [FLAG_SYMS];
  logic [3:0] idle_tab  [FLAG_SYMS];

  for (genvar g = 0; g < PRE_SYMS; g++) begin : g_pre
    assign pre_tab[g] = PRE_PAT[4*g +: 4];
  end

  for (genvar g = 0; g < FLAG_SYMS; g++) begin : g_flag
    assign start_tab[g] = START_FLAG[4*g +: 4];
    assign stop_tab[g]  = STOP_FLAG[4*g +: 4];
    assign idle_tab[g]  = IDLE_FLAG[4*g +: 4];
  end

  logic [PSEL_W-1:0] pre_sel;
  logic [FSEL_W-1:0] flag_sel;

  always_comb begin
    pre_sel  = PSEL_W'(32'(idx_i) % PRE_SYMS);
    flag_sel = (32'(idx_i) < FLAG_SYMS) ? FSEL_W'(idx_i) : '0;
  end

  assign pre_sym_o   = pre_tab[pre_sel];
  assign start_sym_o = start_tab[flag_sel];
  assign stop_sym_o  = stop_tab[flag_sel];
  assign idle_sym_o  = idle_tab[flag_sel];

endmodule

// File: rtl/irfr_ctrl.sv
module irfr_ctrl
  import irfr_pkg::*;
#(
  parameter int PRE_SYMS  = 4,
  parameter int PRE_REPS  = 16,
  parameter int FLAG_SYMS = 8,
  parameter int IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic             sof_i,
  input  logic [7:0]       data_i,
  input  logic             last_i,
  input  logic             valid_i,
  input  logic [3:0]       pre_sym_i,
  input  logic [3:0]       start_sym_i,
  input  logic [3:0]       stop_sym_i,
  input  logic [3:0]       idle_sym_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [3:0]       sym_o,
  output logic             ready_o,
  output logic             urun_o
);

  localparam int PRE_TOTAL = PRE_SYMS * PRE_REPS;
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_TOTAL - 1);
  localparam logic [IDX_W-1:0] FLAG_END = IDX_W'(FLAG_SYMS - 1);

  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       dib_q, dib_d;
  logic [7:0]       byte_q, byte_d;
  logic             last_q, last_d;
  logic             pend_q, pend_d;
  logic             fetch;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    dib_d   = dib_q;
    byte_d  = byte_q;
    last_d  = last_q;
    pend_d  = pend_q | (sof_i && state_q == ST_IDLE);
    sym_o   = '0;
    fetch   = 1'b0;
    urun_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        sym_o = idle_sym_i;
        if (load_i) begin
          if (idx_q == FLAG_END) begin
            idx_d = '0;
            if (pend_q) begin
              state_d = ST_PRE;
              pend_d  = 1'b0;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PRE: begin
        sym_o = pre_sym_i;
        if (load_i) begin
          if (idx_q == PRE_END) begin
            idx_d   = '0;
            state_d = ST_SOF;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_SOF: begin
        sym_o = start_sym_i;
        if (load_i) begin
          if (idx_q == FLAG_END) begin
            idx_d   = '0;
            dib_d   = '0;
            state_d = ST_DATA;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (dib_q == 2'd0) begin
          // byte fetch slot: an empty buffer turns this slot into stop symbol 0
          sym_o = valid_i ? ppm_sym(data_i[7:6]) : stop_sym_i;
          if (load_i) begin
            fetch = 1'b1;
            if (valid_i) begin
              byte_d = data_i;
              last_d = last_i;
              dib_d  = 2'd1;
            end else begin
              urun_o  = 1'b1;
              state_d = ST_EOF;
              idx_d   = IDX_W'(1);
            end
          end
        end else begin
          sym_o = ppm_sym(pick_dibit(byte_q, dib_q));
          if (load_i) begin
            if (dib_q == 2'd3) begin
              dib_d = 2'd0;
              if (last_q) begin
                state_d = ST_EOF;
                idx_d   = '0;
              end
            end else begin
              dib_d = dib_q + 2'd1;
            end
          end
        end
      end
      ST_EOF: begin
        sym_o = stop_sym_i;
        if (load_i) begin
          if (idx_q == FLAG_END) begin
            idx_d   = '0;
            state_d = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ready_o = fetch;
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dib_q   <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      dib_q   <= '0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      dib_q   <= dib_d;
      byte_q  <= byte_d;
      last_q  <= last_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/irfr_serializer.sv
module irfr_serializer
  import irfr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       chip_en_i,
  input  logic [3:0] sym_i,
  output logic       load_o,
  output logic       chip_o,
  output logic       sym_start_o
);

  localparam int CNT_W = $clog2(SYM_CHIPS);

  logic [CNT_W-1:0]     cnt_q;
  logic [SYM_CHIPS-1:0] sh_q;

  assign load_o = enable_i && chip_en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      chip_o      <= 1'b0;
      sym_start_o <= 1'b0;
    end else if (!enable_i) begin
      cnt_q       <= '0;
      chip_o      <= 1'b0;
      sym_start_o <= 1'b0;
    end else if (chip_en_i) begin
      if (cnt_q == '0) begin
        sh_q        <= sym_i;
        chip_o      <= sym_i[0];
        sym_start_o <= 1'b1;
      end else begin
        chip_o      <= sh_q[cnt_q];
        sym_start_o <= 1'b0;
      end
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/irfr_status.sv
module irfr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic pulse_o,
  output logic irq_o
);

  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= evt_i;
      if (evt_i)      sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
    end
  end

  assign irq_o = sts_q & ie_i;

endmodule

// File: rtl/irfr_tx_framer.sv
module irfr_tx_framer #(
  parameter int PRE_SYMS  = 4,
  parameter int PRE_REPS  = 16,
  parameter int FLAG_SYMS = 8,
  parameter logic [4*PRE_SYMS-1:0]  PRE_PAT    = 16'h8421,
  parameter logic [4*FLAG_SYMS-1:0] START_FLAG = 32'h06063030,
  parameter logic [4*FLAG_SYMS-1:0] STOP_FLAG  = 32'h60063030,
  parameter logic [4*FLAG_SYMS-1:0] IDLE_FLAG  = 32'h06063030
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       chip_en_i,
  input  logic       sof_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_last_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       chip_o,
  output logic       sym_start_o,
  input  logic       urun_ie_i,
  input  logic       urun_clr_i,
  output logic       urun_pulse_o,
  output logic       irq_o
);

  localparam int PRE_TOTAL = PRE_SYMS * PRE_REPS;
  localparam int SEG_MAX   = (PRE_TOTAL > FLAG_SYMS) ? PRE_TOTAL : FLAG_SYMS;
  localparam int IDX_W     = (SEG_MAX > 1) ? $clog2(SEG_MAX) : 1;

  logic [IDX_W-1:0] idx;
  logic [3:0]       pre_sym, start_sym, stop_sym, idle_sym, next_sym;
  logic             load, urun_evt;

  irfr_pattern_rom #(
    .PRE_SYMS  (PRE_SYMS),
    .FLAG_SYMS (FLAG_SYMS),
    .IDX_W     (IDX_W),
    .PRE_PAT   (PRE_PAT),
    .START_FLAG(START_FLAG),
    .STOP_FLAG (STOP_FLAG),
    .IDLE_FLAG (IDLE_FLAG)
  ) u_rom (
    .idx_i      (idx),
    .pre_sym_o  (pre_sym),
    .start_sym_o(start_sym),
    .stop_sym_o (stop_sym),
    .idle_sym_o (idle_sym)
  );

  irfr_ctrl #(
    .PRE_SYMS (PRE_SYMS),
    .PRE_REPS (PRE_REPS),
    .FLAG_SYMS(FLAG_SYMS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .load_i     (load),
    .sof_i      (sof_i),
    .data_i     (tx_data_i),
    .last_i     (tx_last_i),
    .valid_i    (tx_valid_i),
    .pre_sym_i  (pre_sym),
    .start_sym_i(start_sym),
    .stop_sym_i (stop_sym),
    .idle_sym_i (idle_sym),
    .idx_o      (idx),
    .sym_o      (next_sym),
    .ready_o    (tx_ready_o),
    .urun_o     (urun_evt)
  );

  irfr_serializer u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .chip_en_i  (chip_en_i),
    .sym_i      (next_sym),
    .load_o     (load),
    .chip_o     (chip_o),
    .sym_start_o(sym_start_o)
  );

  irfr_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (urun_evt),
    .clr_i  (urun_clr_i),
    .ie_i   (urun_ie_i),
    .pulse_o(urun_pulse_o),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/irfr_tx_framer_chk.sv
module irfr_tx_framer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic chip_en_i,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic chip_o,
  input logic sym_start_o,
  input logic urun_ie_i,
  input logic urun_pulse_o,
  input logic irq_o
);

  a_r7_ready_on_chip_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> (enable_i && chip_en_i));

  a_r1_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!chip_o && !sym_start_o && !urun_pulse_o));

  a_r2_hold_without_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && !$past(chip_en_i)) |-> $stable(chip_o));

  a_r2_start_on_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sym_start_o) |-> $past(chip_en_i));

  a_r9_urun_on_empty_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> urun_pulse_o);

  a_r10_urun_only_at_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urun_pulse_o |-> $past(tx_ready_o && !tx_valid_i));

  a_r11_irq_on_enabled_urun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_pulse_o && urun_ie_i) |-> irq_o);

endmodule

bind irfr_tx_framer irfr_tx_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .chip_en_i   (chip_en_i),
  .tx_valid_i  (tx_valid_i),
  .tx_ready_o  (tx_ready_o),
  .chip_o      (chip_o),
  .sym_start_o (sym_start_o),
  .urun_ie_i   (urun_ie_i),
  .urun_pulse_o(urun_pulse_o),
  .irq_o       (irq_o)
);

// File: tb/irfr_tx_framer_tb.sv
`timescale 1ns/1ps
module irfr_tx_framer_tb;

  localparam int PRE_SYMS  = 4;
  localparam int PRE_REPS  = 16;
  localparam int FLAG_SYMS = 8;
  localparam logic [15:0] PRE_PAT    = 16'h8421;
  localparam logic [31:0] START_FLAG = 32'h06063030;
  localparam logic [31:0] STOP_FLAG  = 32'h60063030;
  localparam logic [31:0] IDLE_FLAG  = 32'h06063030;
  localparam int WDOG = 190000;

  typedef struct {
    int    sym;
    string req;
  } exp_t;
  typedef logic [7:0] bytes_t[$];

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       chip_en_i = 1'b0;
  logic       sof_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_last_i = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic       tx_ready_o, chip_o, sym_start_o, urun_pulse_o, irq_o;
  logic       urun_ie_i = 1'b0;
  logic       urun_clr_i = 1'b0;

  irfr_tx_framer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .chip_en_i   (chip_en_i),
    .sof_i       (sof_i),
    .tx_data_i   (tx_data_i),
    .tx_last_i   (tx_last_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .chip_o      (chip_o),
    .sym_start_o (sym_start_o),
    .urun_ie_i   (urun_ie_i),
    .urun_clr_i  (urun_clr_i),
    .urun_pulse_o(urun_pulse_o),
    .irq_o       (irq_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int ce_div = 2, ce_cnt = 0;
  exp_t   exp_q[$];
  bytes_t bq;
  bit     cur_eof = 0;
  logic   ce_seen = 0, en_seen = 0, acc_seen = 0;
  int     pos = 0, idle_idx = 0, frames = 0, urun_cnt = 0, acc_cnt = 0;
  bit     in_frame = 0, first_after_en = 0;
  logic [3:0] col;

  function automatic void chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endfunction

  function automatic int idle_sym(input int j);
    return int'(IDLE_FLAG[4*j +: 4]);
  endfunction

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    ce_seen  <= chip_en_i && enable_i;
    en_seen  <= enable_i;
    acc_seen <= tx_valid_i && tx_ready_o;
  end

  // chip-enable generator
  always @(negedge clk) begin
    ce_cnt = ce_cnt + 1;
    if (ce_cnt >= ce_div) begin
      chip_en_i = 1'b1;
      ce_cnt = 0;
    end else begin
      chip_en_i = 1'b0;
    end
  end

  // byte source model of the upstream buffer
  always @(negedge clk) begin
    if (acc_seen && bq.size() > 0) begin
      void'(bq.pop_front());
      acc_cnt++;
    end
    tx_valid_i = (bq.size() > 0);
    tx_data_i  = (bq.size() > 0) ? bq[0] : 8'h00;
    tx_last_i  = cur_eof && (bq.size() == 1);
  end

  // monitor: assembles symbols and compares against the scoreboard
  always @(negedge clk) begin
    if (urun_pulse_o) urun_cnt++;
    if (!en_seen) begin
      pos = 0;
      in_frame = 0;
      idle_idx = 0;
      first_after_en = 1;
    end else if (ce_seen) begin
      chk(sym_start_o == (pos == 0), "R2 sym_start", int'(sym_start_o), int'(pos == 0));
      col[pos] = chip_o;
      pos++;
      if (pos == 4) begin
        pos = 0;
        if (!in_frame) begin
          if (idle_idx == 0 && col == 4'h1) begin
            frames++;
            if (exp_q.size() == 0) begin
              chk(0, "R12 unexpected frame", int'(col), 0);
            end else begin
              exp_t e;
              in_frame = 1;
              e = exp_q.pop_front();
              chk(int'(col) == e.sym, e.req, int'(col), e.sym);
            end
          end else begin
            chk(int'(col) == idle_sym(idle_idx), first_after_en ? "R1 first idle" : "R3 idle flag",
                int'(col), idle_sym(idle_idx));
            idle_idx = (idle_idx + 1) % FLAG_SYMS;
          end
          first_after_en = 0;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(col) == e.sym, e.req, int'(col), e.sym);
          if (exp_q.size() == 0) begin
            in_frame = 0;
            idle_idx = 0;
          end
        end
      end
    end
  end

  task automatic send_frame(input bytes_t b, input bit eof);
    for (int k = 0; k < PRE_SYMS*PRE_REPS; k++)
      exp_q.push_back('{int'(PRE_PAT[4*(k%PRE_SYMS) +: 4]), "R4 preamble"});
    for (int k = 0; k < FLAG_SYMS; k++)
      exp_q.push_back('{int'(START_FLAG[4*k +: 4]), "R5 start flag"});
    foreach (b[i])
      for (int d = 3; d >= 0; d--)
        exp_q.push_back('{1 << ((b[i] >> (2*d)) & 8'h3), "R6 data symbol"});
    for (int k = 0; k < FLAG_SYMS; k++)
      exp_q.push_back('{int'(STOP_FLAG[4*k +: 4]), eof ? "R8 stop flag" : "R9 stop flag"});
    @(negedge clk);
    cur_eof = eof;
    foreach (b[i]) bq.push_back(b[i]);
    @(negedge clk);
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  task automatic wait_done(input int tail);
    while ((exp_q.size() != 0 || in_frame) && cyc < WDOG) @(negedge clk);
    repeat (tail) @(negedge clk);
  endtask

  initial begin
    wait (cyc >= WDOG);
    chk(0, "watchdog", cyc, WDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bytes_t none;
    int u0, a0;
    repeat (4) @(negedge clk);
    chk(chip_o == 0, "R1 reset chip", int'(chip_o), 0);
    chk(tx_ready_o == 0, "R1 reset ready", int'(tx_ready_o), 0);
    chk(urun_pulse_o == 0, "R1 reset urun", int'(urun_pulse_o), 0);
    chk(irq_o == 0, "R11 reset irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(chip_o == 0 && sym_start_o == 0, "R1 disabled", int'(chip_o), 0);

    // idle with an empty buffer
    enable_i = 1'b1;
    repeat (400) @(negedge clk);
    chk(urun_cnt == 0, "R10 idle no underrun", urun_cnt, 0);
    chk(frames == 0, "R3 idle only", frames, 0);

    // frame with last tag, plus a start strobe mid-frame
    send_frame('{8'h1B, 8'hE4, 8'h00, 8'hFF}, 1);
    repeat (300) @(negedge clk);
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
    wait_done(600);
    chk(frames == 1, "R12 no extra frame", frames, 1);
    chk(urun_cnt == 0, "R8 no underrun", urun_cnt, 0);
    chk(acc_cnt == 4, "R7 bytes taken", acc_cnt, 4);

    // underrun after two bytes, interrupt disabled
    ce_div = 3;
    a0 = acc_cnt;
    send_frame('{8'hA5, 8'h3C}, 0);
    wait_done(100);
    chk(urun_cnt == 1, "R9 underrun count", urun_cnt, 1);
    chk(acc_cnt - a0 == 2, "R7 bytes taken", acc_cnt - a0, 2);
    chk(irq_o == 0, "R11 masked irq", int'(irq_o), 0);
    urun_ie_i = 1'b1;
    @(negedge clk);
    chk(irq_o == 1, "R11 irq enabled", int'(irq_o), 1);
    urun_clr_i = 1'b1;
    @(negedge clk);
    urun_clr_i = 1'b0;
    @(negedge clk);
    chk(irq_o == 0, "R11 cleared", int'(irq_o), 0);

    // empty frame: underrun at the first fetch
    ce_div = 1;
    u0 = urun_cnt;
    send_frame(none, 0);
    wait_done(100);
    chk(urun_cnt - u0 == 1, "R9 empty frame underrun", urun_cnt - u0, 1);
    chk(irq_o == 1, "R11 irq on underrun", int'(irq_o), 1);
    urun_clr_i = 1'b1;
    @(negedge clk);
    urun_clr_i = 1'b0;

    // normal frame at chip_en every clock
    u0 = urun_cnt;
    send_frame('{8'h5A, 8'hC3}, 1);
    wait_done(200);
    chk(urun_cnt == u0, "R10 no underrun before payload", urun_cnt, u0);

    // disable in mid-frame
    ce_div = 2;
    send_frame('{8'h11, 8'h22, 8'h33}, 1);
    repeat (200) @(negedge clk);
    enable_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(chip_o == 0, "R1 disable chip", int'(chip_o), 0);
    chk(sym_start_o == 0, "R1 disable sym_start", int'(sym_start_o), 0);
    chk(tx_ready_o == 0, "R1 disable ready", int'(tx_ready_o), 0);
    exp_q.delete();
    bq.delete();
    repeat (10) @(negedge clk);
    enable_i = 1'b1;
    repeat (400) @(negedge clk);
    chk(frames == 5, "R1 no frame after re-enable", frames, 5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule